// File: doc/BRIEF.md
# Trigger-Matched Hit Buffer

This block sits at the foot of one pixel column region. It keeps recent hits until the level-1 trigger decision for their bunch crossing is due. Each hit arrives with a pixel address, a time-over-threshold value and a Gray-coded leading-edge stamp. It takes one of a small set of shared slots. The block also runs the free-running Gray-coded bunch-crossing counter that the pixel matrix uses to stamp its hits.

Every stored hit is aged against a programmable trigger latency. When a trigger arrives, each entry whose stamp equals the current crossing minus the latency is kept for readout and tagged with a trigger number. It is then sent on a valid/ready port in ascending slot order. An entry that reaches the latency with no trigger is discarded. Entries therefore leave in trigger order, not in arrival order. Up to two triggers can wait while an earlier readout is still draining.

Top module: `trig_hit_buffer`

## Requirements
- R1: The crossing counter reads 0 while reset is held. It then advances by one every clock, modulo 256, and `bx_gray` shows its Gray code (b ^ (b >> 1)), so consecutive values differ in exactly one bit.
- R2: A hit is stored only if its arrival age (current crossing minus the binary value of `hit_ts_gray`, modulo 256) is less than `latency`. Any other hit is dropped without taking a slot and without touching `ovf_count`. `latency` must lie in 1..255 and stay constant while hits are held.
- R3: An accepted hit goes into the lowest-numbered free slot. At most one hit is taken per clock.
- R4: A trigger seen at crossing T selects every stored entry whose stamp decodes to T - `latency` (modulo 256). A hit presented in the same clock as the trigger is not part of that selection.
- R5: A stored, unselected entry is freed at the end of the clock in which its age equals `latency`, unless a trigger is accepted in that clock.
- R6: The entries selected by one trigger are output in ascending slot order. All of them carry the same `rd_trig_id`: 0 for the first trigger accepted after reset, plus one (modulo 16) for each later accepted trigger.
- R7: While `rd_valid` is high and `rd_ready` is low, all read fields hold steady. A selected entry is freed only in the clock in which it is accepted (`rd_valid` and `rd_ready` both high).
- R8: Up to two accepted triggers can be pending, and they are served in arrival order. A trigger that arrives while two are pending is ignored: it uses no trigger number and selects nothing.
- R9: A hit that passes R2 while all slots are occupied is discarded, and `ovf_count` increases by one, saturating at all ones.
- R10: Holding `rst_n` low at a clock edge empties all slots and the trigger queue, and clears the trigger numbering, `ovf_count` and the crossing counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| latency | input | 8 | Trigger latency in crossings (1..255) |
| bx_gray | output | 8 | Gray-coded crossing counter for the pixel matrix |
| hit_valid | input | 1 | A hit is presented this clock |
| hit_ts_gray | input | 8 | Gray-coded leading-edge stamp of the hit |
| hit_addr | input | ADDR_W | Pixel address of the hit |
| hit_tot | input | TOT_W | Time-over-threshold of the hit |
| l1_trig | input | 1 | Level-1 trigger pulse |
| rd_valid | output | 1 | A selected entry is offered |
| rd_ready | input | 1 | Consumer accepts the offered entry |
| rd_addr | output | ADDR_W | Pixel address of the offered entry |
| rd_tot | output | TOT_W | Time-over-threshold of the offered entry |
| rd_ts_gray | output | 8 | Gray stamp of the offered entry |
| rd_trig_id | output | ID_W | Trigger number of the offered entry |
| ovf_count | output | OVF_W | Saturating count of hits lost to a full buffer |

## Verification
The bench aims at the age boundary. A hit whose age equals the latency must still be selectable by a trigger, and it must be gone one clock later. An off-by-one comparison would either emit a stale hit or lose an on-time one. Stalled readout is tested with two queued triggers and a third that must be ignored. A design that freed entries before acceptance, or that consumed a trigger number for the ignored trigger, would give wrong entries or wrong numbers. A slot is freed in the middle of the buffer and refilled, so a design that emitted in arrival order instead of slot order shows the wrong sequence. Stale hits offered to a full buffer, and saturation of the overflow count, catch designs that count or store the wrong hits.

// File: rtl/thb_pkg.sv
// Shared types and Gray-code helpers for the trigger-matched hit buffer.
// Assumes an 8-bit crossing stamp; all age arithmetic is modulo 2**TS_W.
package thb_pkg;
    localparam int TS_W = 8;
    typedef logic [TS_W-1:0] ts_t;

    // Binary to reflected Gray code.
    function automatic ts_t bin2gray(input ts_t b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary, MSB first.
    function automatic ts_t gray2bin(input ts_t g);
        ts_t b;
        b[TS_W-1] = g[TS_W-1];
        for (int i = TS_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/thb_bx_counter.sv
// Free-running bunch-crossing counter.
// Holds 0 under reset, then counts up once per clock and wraps at 2**TS_W.
// Provides the binary value for age arithmetic and its Gray code for the matrix.
module thb_bx_counter
    import thb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output ts_t  now_bin,
    output ts_t  now_gray
);
    ts_t cnt_q;

    // Advance the crossing count every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Gray view of the registered count.
    assign now_bin  = cnt_q;
    assign now_gray = bin2gray(cnt_q);
endmodule

// File: rtl/thb_first_set.sv
// Lowest-index priority picker returning a one-hot grant.
// Assumes nothing about req; grant is all zeros when req is empty.
module thb_first_set #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan from index 0 upward and keep only the first request.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/thb_trig_queue.sv
// Pending-trigger queue with trigger numbering.
// Each accepted trigger takes the next number (wrapping at 2**ID_W) and is queued.
// A push is refused when DEPTH entries are pending, even if a pop happens in the
// same clock. The head is valid whenever the queue is not empty.
module thb_trig_queue #(
    parameter int DEPTH = 2,
    parameter int ID_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic            accept,
    output logic [ID_W-1:0] new_id,
    output logic [ID_W-1:0] head_id,
    output logic            not_empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [ID_W-1:0] ids_q [DEPTH];
    logic [PW-1:0]   rp_q, wp_q;
    logic [CW-1:0]   cnt_q;
    logic            do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (cnt_q != '0);
    assign do_pop    = pop && not_empty;
    assign accept    = push && (cnt_q != CW'(DEPTH));
    assign head_id   = ids_q[rp_q];

    // Pointer, fill level and numbering bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q   <= '0;
            wp_q   <= '0;
            cnt_q  <= '0;
            new_id <= '0;
        end else begin
            if (accept) begin
                wp_q   <= step(wp_q);
                new_id <= new_id + 1'b1;
            end
            if (do_pop) rp_q <= step(rp_q);
            cnt_q <= cnt_q + CW'(accept) - CW'(do_pop);
        end
    end

    // Store the number of each accepted trigger.
    always_ff @(posedge clk) begin
        if (accept) ids_q[wp_q] <= new_id;
    end
endmodule

// File: rtl/thb_slot_array.sv
// Hit storage slots with per-slot ageing and trigger selection.
// Each slot holds stamp, address and ToT, plus a "held" flag and the trigger
// number once a trigger has selected it. An unheld slot whose age equals the
// latency is either selected (trigger accepted this clock) or freed.
// Assumes wr_sel only targets free slots and drain_sel only held slots.
module thb_slot_array
    import thb_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 10,
    parameter int TOT_W  = 4,
    parameter int ID_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  ts_t                     now_bin,
    input  ts_t                     latency,
    input  logic [N-1:0]            wr_sel,
    input  ts_t                     wr_ts_gray,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [TOT_W-1:0]        wr_tot,
    input  logic                    trig_take,
    input  logic [ID_W-1:0]         trig_id,
    input  logic [N-1:0]            drain_sel,
    input  logic                    drain_fire,
    input  logic                    head_live,
    input  logic [ID_W-1:0]         head_id,
    output logic [N-1:0]            occ,
    output logic [N-1:0]            ready_mask,
    output logic [N-1:0][ADDR_W-1:0] q_addr,
    output logic [N-1:0][TOT_W-1:0]  q_tot,
    output logic [N-1:0][TS_W-1:0]   q_ts
);
    for (genvar s = 0; s < N; s++) begin : g_slot
        logic              occ_q;
        logic              held_q;
        logic [ID_W-1:0]   tag_q;
        ts_t               ts_q;
        logic [ADDR_W-1:0] addr_q;
        logic [TOT_W-1:0]  tot_q;
        ts_t               age;
        logic              due;

        assign age = now_bin - gray2bin(ts_q);
        assign due = occ_q && !held_q && (age == latency);

        // Slot state: fill, drain, select at latency or expire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_q  <= 1'b0;
                held_q <= 1'b0;
                tag_q  <= '0;
            end else if (wr_sel[s]) begin
                occ_q  <= 1'b1;
                held_q <= 1'b0;
            end else if (drain_fire && drain_sel[s]) begin
                occ_q  <= 1'b0;
                held_q <= 1'b0;
            end else if (due) begin
                if (trig_take) begin
                    held_q <= 1'b1;
                    tag_q  <= trig_id;
                end else begin
                    occ_q <= 1'b0;
                end
            end
        end

        // Hit payload capture.
        always_ff @(posedge clk) begin
            if (wr_sel[s]) begin
                ts_q   <= wr_ts_gray;
                addr_q <= wr_addr;
                tot_q  <= wr_tot;
            end
        end

        assign occ[s]        = occ_q;
        assign ready_mask[s] = occ_q && held_q && head_live && (tag_q == head_id);
        assign q_addr[s]     = addr_q;
        assign q_tot[s]      = tot_q;
        assign q_ts[s]       = ts_q;
    end
endmodule

// File: rtl/trig_hit_buffer.sv
// Trigger-matched hit buffer for one column region.
// Drives the Gray crossing counter, admits hits younger than the latency into
// the lowest free slot, lets triggers select entries at exactly the latency,
// and drains selected entries over valid/ready in slot order per trigger.
// Assumes latency in 1..255 and constant while hits are held.
module trig_hit_buffer
    import thb_pkg::*;
#(
    parameter int N_SLOTS  = 8,
    parameter int ADDR_W   = 10,
    parameter int TOT_W    = 4,
    parameter int ID_W     = 4,
    parameter int OVF_W    = 8,
    parameter int TQ_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   latency,
    output logic [TS_W-1:0]   bx_gray,
    input  logic              hit_valid,
    input  logic [TS_W-1:0]   hit_ts_gray,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic [TOT_W-1:0]  hit_tot,
    input  logic              l1_trig,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [TOT_W-1:0]  rd_tot,
    output logic [TS_W-1:0]   rd_ts_gray,
    output logic [ID_W-1:0]   rd_trig_id,
    output logic [OVF_W-1:0]  ovf_count
);
    ts_t                         now_bin;
    ts_t                         arr_age;
    logic                        hit_fresh;
    logic [N_SLOTS-1:0]          occ;
    logic [N_SLOTS-1:0]          free_grant;
    logic                        any_free;
    logic [N_SLOTS-1:0]          wr_sel;
    logic [N_SLOTS-1:0]          ready_mask;
    logic [N_SLOTS-1:0]          drain_sel;
    logic                        any_ready;
    logic                        rd_fire;
    logic                        trig_take;
    logic [ID_W-1:0]             trig_id;
    logic [ID_W-1:0]             head_id;
    logic                        head_live;
    logic [N_SLOTS-1:0][ADDR_W-1:0] q_addr;
    logic [N_SLOTS-1:0][TOT_W-1:0]  q_tot;
    logic [N_SLOTS-1:0][TS_W-1:0]   q_ts;

    thb_bx_counter i_bx (
        .clk      (clk),
        .rst_n    (rst_n),
        .now_bin  (now_bin),
        .now_gray (bx_gray)
    );

    // Admission: hit must be younger than the latency.
    assign arr_age   = now_bin - gray2bin(hit_ts_gray);
    assign hit_fresh = hit_valid && (arr_age < latency);

    thb_first_set #(.N(N_SLOTS)) i_free_pick (
        .req   (~occ),
        .grant (free_grant),
        .any   (any_free)
    );

    assign wr_sel = hit_fresh ? free_grant : '0;

    thb_trig_queue #(.DEPTH(TQ_DEPTH), .ID_W(ID_W)) i_tq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (l1_trig),
        .pop       (!any_ready),
        .accept    (trig_take),
        .new_id    (trig_id),
        .head_id   (head_id),
        .not_empty (head_live)
    );

    thb_slot_array #(
        .N      (N_SLOTS),
        .ADDR_W (ADDR_W),
        .TOT_W  (TOT_W),
        .ID_W   (ID_W)
    ) i_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_bin    (now_bin),
        .latency    (latency),
        .wr_sel     (wr_sel),
        .wr_ts_gray (hit_ts_gray),
        .wr_addr    (hit_addr),
        .wr_tot     (hit_tot),
        .trig_take  (trig_take),
        .trig_id    (trig_id),
        .drain_sel  (drain_sel),
        .drain_fire (rd_fire),
        .head_live  (head_live),
        .head_id    (head_id),
        .occ        (occ),
        .ready_mask (ready_mask),
        .q_addr     (q_addr),
        .q_tot      (q_tot),
        .q_ts       (q_ts)
    );

    thb_first_set #(.N(N_SLOTS)) i_drain_pick (
        .req   (ready_mask),
        .grant (drain_sel),
        .any   (any_ready)
    );

    assign rd_valid   = any_ready;
    assign rd_fire    = rd_valid && rd_ready;
    assign rd_trig_id = head_id;

    // One-hot AND-OR mux of the granted slot onto the read port.
    always_comb begin
        rd_addr    = '0;
        rd_tot     = '0;
        rd_ts_gray = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (drain_sel[i]) begin
                rd_addr    = rd_addr    | q_addr[i];
                rd_tot     = rd_tot     | q_tot[i];
                rd_ts_gray = rd_ts_gray | q_ts[i];
            end
        end
    end

    // Saturating count of admissible hits lost to a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        ovf_count <= '0;
        else if (hit_fresh && !any_free && ovf_count != '1) ovf_count <= ovf_count + 1'b1;
    end
endmodule

// File: rtl/thb_checker.sv
// Property checker for trig_hit_buffer, attached by bind below.
// Watches the ports plus slot occupancy and the admission decision.
module thb_checker
    import thb_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 10,
    parameter int TOT_W  = 4,
    parameter int ID_W   = 4,
    parameter int OVF_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TS_W-1:0]   bx_gray,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [TOT_W-1:0]  rd_tot,
    input logic [TS_W-1:0]   rd_ts_gray,
    input logic [ID_W-1:0]   rd_trig_id,
    input logic [OVF_W-1:0]  ovf_count,
    input logic              hit_fresh,
    input logic [N-1:0]      occ
);
    logic      armed;
    ts_t       bx_prev;

    // Track the previous stamp once out of reset.
    always_ff @(posedge clk) begin
        armed   <= rst_n;
        bx_prev <= bx_gray;
    end

    a_r1_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ($countones(bx_gray ^ bx_prev) == 1));

    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_tot)
                                     && $stable(rd_ts_gray) && $stable(rd_trig_id)));

    a_r9_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_fresh && (&occ) && (ovf_count != {OVF_W{1'b1}})) |=> (ovf_count == $past(ovf_count) + 1'b1));

    a_r9_ovf_mono: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovf_count >= $past(ovf_count)));

    a_r3_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(occ) <= $countones($past(occ)) + 1));
endmodule

bind trig_hit_buffer thb_checker #(
    .N      (N_SLOTS),
    .ADDR_W (ADDR_W),
    .TOT_W  (TOT_W),
    .ID_W   (ID_W),
    .OVF_W  (OVF_W)
) i_thb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bx_gray    (bx_gray),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rd_tot     (rd_tot),
    .rd_ts_gray (rd_ts_gray),
    .rd_trig_id (rd_trig_id),
    .ovf_count  (ovf_count),
    .hit_fresh  (hit_fresh),
    .occ        (occ)
);

// File: tb/test_trig_hit_buffer.sv
module test_trig_hit_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int TOT_W  = 4;
    localparam int ID_W   = 4;
    localparam int OVF_W  = 8;

    // Vector: {latency, expected count, hit count, trigger offset from first stamp}
    localparam logic [31:0] VEC [8] = '{
        {8'd1,   8'd1, 8'd1, 8'd0},
        {8'd3,   8'd1, 8'd3, 8'd2},
        {8'd3,   8'd0, 8'd3, 8'd3},
        {8'd7,   8'd1, 8'd4, 8'd1},
        {8'd20,  8'd0, 8'd2, 8'd5},
        {8'd255, 8'd1, 8'd2, 8'd1},
        {8'd2,   8'd1, 8'd1, 8'd0},
        {8'd12,  8'd1, 8'd5, 8'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        latency = 8'd1;
    logic [7:0]        bx_gray;
    logic              hit_valid = 1'b0;
    logic [7:0]        hit_ts_gray = '0;
    logic [ADDR_W-1:0] hit_addr = '0;
    logic [TOT_W-1:0]  hit_tot = '0;
    logic              l1_trig = 1'b0;
    logic              rd_valid;
    logic              rd_ready = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic [TOT_W-1:0]  rd_tot;
    logic [7:0]        rd_ts_gray;
    logic [ID_W-1:0]   rd_trig_id;
    logic [OVF_W-1:0]  ovf_count;

    int n_cmp = 0;
    int n_bad = 0;
    int tb_bx = 0;
    int got_cnt = 0;
    logic [ADDR_W-1:0] got_addr [16];
    logic [ID_W-1:0]   got_id   [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_hit_buffer i_trig_hit_buffer (
        .clk(clk), .rst_n(rst_n), .latency(latency), .bx_gray(bx_gray),
        .hit_valid(hit_valid), .hit_ts_gray(hit_ts_gray), .hit_addr(hit_addr),
        .hit_tot(hit_tot), .l1_trig(l1_trig), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_addr(rd_addr), .rd_tot(rd_tot), .rd_ts_gray(rd_ts_gray),
        .rd_trig_id(rd_trig_id), .ovf_count(ovf_count)
    );

    // Bench copy of the crossing number (R1 model).
    always @(posedge clk) tb_bx <= rst_n ? tb_bx + 1 : 0;

    // Record every accepted read beat, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rd_valid && rd_ready && got_cnt < 16) begin
            got_addr[got_cnt] = rd_addr;
            got_id[got_cnt]   = rd_trig_id;
            got_cnt = got_cnt + 1;
        end
    end

    function automatic logic [7:0] g(input int v);
        logic [7:0] b;
        b = v[7:0];
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; hit_valid = 1'b0; l1_trig = 1'b0; rd_ready = 1'b0;
        tick; tick;
        rst_n = 1'b1;
    endtask

    task automatic send_hit(input int ts, input int addr);
        hit_valid = 1'b1;
        hit_ts_gray = g(ts);
        hit_addr = ADDR_W'(addr);
        hit_tot = TOT_W'(addr);
        tick;
        hit_valid = 1'b0;
    endtask

    task automatic trig_at(input int t);
        while (tb_bx < t) tick;
        l1_trig = 1'b1;
        tick;
        l1_trig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R0 actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s;
        do_reset;
        // R10: reset state
        @(negedge clk);
        chk(!rd_valid, "R10 rd_valid after reset", int'(rd_valid), 0);
        chk(ovf_count == 0, "R10 ovf after reset", int'(ovf_count), 0);
        chk(bx_gray == 8'd0, "R10 counter after reset", int'(bx_gray), 0);

        // R1: Gray counter follows the crossing number through a wrap
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            chk(bx_gray == g(tb_bx), "R1 gray counter", int'(bx_gray), int'(g(tb_bx)));
        end

        // Vector table: R4 selection at the latency, R5 expiry, R6 numbering
        for (int v = 0; v < 8; v++) begin
            int lat, exp_n, nh, k;
            lat = int'(VEC[v][31:24]); exp_n = int'(VEC[v][23:16]);
            nh = int'(VEC[v][15:8]);   k = int'(VEC[v][7:0]);
            do_reset;
            latency = 8'(lat);
            rd_ready = 1'b1;
            tick;
            s = tb_bx;
            for (int j = 0; j < nh; j++) send_hit(tb_bx, 16 * v + j);
            got_cnt = 0;
            trig_at(s + k + lat);
            repeat (6) tick;
            @(negedge clk);
            chk(got_cnt == exp_n, exp_n ? "R4 match count" : "R5 expired count", got_cnt, exp_n);
            if (exp_n == 1 && got_cnt == 1) begin
                chk(got_addr[0] == ADDR_W'(16 * v + k), "R4 matched address", int'(got_addr[0]), 16 * v + k);
                chk(got_id[0] == 0, "R6 first trigger number", int'(got_id[0]), 0);
            end
        end

        // R7/R8/R6: stalled readout, two queued triggers, third ignored
        do_reset;
        latency = 8'd10;
        tick;
        s = tb_bx;
        send_hit(s, 1); send_hit(s, 2); send_hit(s + 1, 3); send_hit(s, 4);
        got_cnt = 0;
        trig_at(s + 10);
        trig_at(s + 11);
        trig_at(s + 12);
        repeat (3) tick;
        @(negedge clk);
        chk(rd_valid && rd_addr == 1, "R7 offered while stalled", int'(rd_addr), 1);
        tick;
        @(negedge clk);
        chk(rd_addr == 1 && got_cnt == 0, "R7 held while stalled", int'(rd_addr), 1);
        tick;
        rd_ready = 1'b1;
        repeat (8) tick;
        @(negedge clk);
        chk(got_cnt == 4, "R8 entries from two triggers", got_cnt, 4);
        chk(got_addr[0] == 1 && got_addr[1] == 2 && got_addr[2] == 4,
            "R6 slot order first trigger", int'(got_addr[2]), 4);
        chk(got_id[0] == 0 && got_id[2] == 0, "R6 first trigger number", int'(got_id[2]), 0);
        chk(got_addr[3] == 3 && got_id[3] == 1, "R8 second trigger served next", int'(got_id[3]), 1);
        tick;
        s = tb_bx;
        send_hit(s, 9);
        got_cnt = 0;
        trig_at(s + 10);
        repeat (4) tick;
        @(negedge clk);
        chk(got_cnt == 1 && got_id[0] == 2, "R8 ignored trigger takes no number", int'(got_id[0]), 2);

        // R3: lowest free slot reused; readout by slot, not arrival
        do_reset;
        latency = 8'd60;
        rd_ready = 1'b1;
        tick;
        s = tb_bx;
        send_hit(s, 17); send_hit(s - 20, 18); send_hit(s, 19);
        got_cnt = 0;
        trig_at(s + 40);
        repeat (4) tick;
        @(negedge clk);
        chk(got_cnt == 1 && got_addr[0] == 18, "R4 older stamp selected", int'(got_addr[0]), 18);
        tick;
        send_hit(s, 20);
        got_cnt = 0;
        trig_at(s + 60);
        repeat (6) tick;
        @(negedge clk);
        chk(got_cnt == 3, "R3 three entries", got_cnt, 3);
        chk(got_addr[0] == 17 && got_addr[1] == 20 && got_addr[2] == 19,
            "R3 refilled slot order", int'(got_addr[1]), 20);

        // R2/R9: stale hits take no slot and are not counted
        do_reset;
        latency = 8'd100;
        tick;
        send_hit(tb_bx - 100, 32);
        for (int i = 0; i < 8; i++) send_hit(tb_bx, i);
        send_hit(tb_bx - 150, 33);
        @(negedge clk);
        chk(ovf_count == 0, "R2 stale hits ignored", int'(ovf_count), 0);
        tick;
        send_hit(tb_bx, 34);
        @(negedge clk);
        chk(ovf_count == 1, "R9 fresh hit on full buffer", int'(ovf_count), 1);

        // R9: overflow count and saturation
        do_reset;
        latency = 8'd255;
        tick;
        for (int i = 0; i < 11; i++) send_hit(tb_bx, i);
        @(negedge clk);
        chk(ovf_count == 3, "R9 overflow count", int'(ovf_count), 3);
        tick;
        for (int i = 0; i < 290; i++) send_hit(tb_bx, i);
        @(negedge clk);
        chk(ovf_count == 8'hFF, "R9 overflow saturates", int'(ovf_count), 255);

        // R10: reset clears the count again
        tick;
        do_reset;
        @(negedge clk);
        chk(ovf_count == 0 && !rd_valid, "R10 reset after activity", int'(ovf_count), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule